// File: doc/BRIEF.md
# Debug Link Transaction Parser

This block sits behind the bit-level receiver of a single-wire debug link. It takes in frames that the link has already acknowledged, one per handshake, and follows the transaction they form. A transaction opens with a short command frame. A system-reset command finishes at once. A read-on-the-fly or write-on-the-fly command is followed by a byte count, then a 24-bit address sent as three bytes with the most significant byte first, and then the data bytes.

The parser reports each command with a pulse and its code, and raises a flag for codes it does not recognise. When the address is complete it pulses an address strobe. Each data byte goes out on a valid/ready stream together with the frame's direction bit and a last marker. The `byte_mode` output tells the receiver how long the next frame is: a 3-bit command when low, an 8-bit byte when high. A pulse on `sync_clear` at any point sends the parser back to waiting for a command.

Back-pressure rules: an input frame is taken in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is low in any cycle where a data beat is held (`dat_valid` high with `dat_ready` low) and in any cycle where `sync_clear` is high. A beat on the data output stays in place, unchanged, until the sink accepts it with `dat_ready`. A beat already on the output is not dropped by `sync_clear`.

Top module: `dbg_txn_parser`

## Requirements
- R1: After reset `byte_mode`, `cmd_strobe`, `cmd_unknown`, `addr_strobe` and `dat_valid` are 0, `addr_out` is 0 and `in_ready` is 1.
- R2: In command state only `in_data[2:0]` is decoded and the upper bits are ignored. Code 0 (system reset) gives a one-cycle `cmd_strobe` with `cmd_code`=0 and `cmd_unknown`=0, and the parser stays in command state.
- R3: Code 1 (read on the fly) and code 2 (write on the fly) each give a `cmd_strobe` with that code and `cmd_unknown`=0, and move the parser to the byte-count state.
- R4: Codes 3 to 7 give `cmd_strobe` together with `cmd_unknown`=1, and the parser stays in command state.
- R5: After read or write, the next frame is the byte count. The three frames after it form the address, most significant byte first: `addr_out` = {first, second, third}. `addr_strobe` is high for one cycle, in the cycle after the third address frame is taken. Count and address frames produce no data beat.
- R6: `byte_mode` is 0 exactly when the parser is in command state, and 1 in the count, address and data states.
- R7: In the data phase, a count of N≥1 gives N data beats and a count of 0 gives one beat. `dat_last` is 1 only on the final beat, and the parser then returns to command state. The remaining count never increases except when a new count is loaded.
- R8: `dat_dir` on each data beat is the direction bit `in_dir` of the frame that carried the byte (0 = sent by the host, a write; 1 = sent by the target, a read). `dat_byte` is the frame's `in_data`.
- R9: While `dat_valid` is 1 and `dat_ready` is 0, `in_ready` is 0 and `dat_byte`, `dat_dir` and `dat_last` hold their values. A beat leaves the output on the first edge at which `dat_ready` is 1.
- R10: When `sync_clear` is 1, `in_ready` is 0 and no frame is taken. In the next cycle the parser is in command state, `addr_out` is 0 and the remaining count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_clear | input | 1 | Synchronisation frame seen; return to command state |
| in_valid | input | 1 | Acknowledged frame available |
| in_ready | output | 1 | Parser takes the frame this cycle |
| in_data | input | 8 | Frame payload (command in bits 2:0) |
| in_dir | input | 1 | Frame start bit: 0 host, 1 target |
| byte_mode | output | 1 | 0: next frame is a 3-bit command, 1: an 8-bit byte |
| cmd_strobe | output | 1 | One-cycle pulse per command frame |
| cmd_code | output | 3 | Code of the last command |
| cmd_unknown | output | 1 | Pulse with `cmd_strobe` for unrecognised codes |
| addr_strobe | output | 1 | One-cycle pulse when the address is complete |
| addr_out | output | 24 | Assembled address |
| dat_valid | output | 1 | Data beat valid |
| dat_ready | input | 1 | Sink accepts the data beat |
| dat_byte | output | 8 | Data byte |
| dat_dir | output | 1 | Direction of the data byte |
| dat_last | output | 1 | Final beat of the transaction |

## Verification
The hardest state to reach is a synchronisation pulse arriving in the middle of a transaction, during address assembly or partway through a counted data phase. At that moment a frame is offered in the same cycle and must be refused, and the partial address and count must be dropped. The bench drives such pulses at chosen points inside directed transactions, with a frame presented at the same time. It then checks that a fresh command is decoded normally. Random transactions also hold the data sink back for random stretches, so that beats stay parked on the output while more frames are waiting.

// File: rtl/dbg_txn_pkg.sv
package dbg_txn_pkg;
  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_COUNT = 2'd1,
    PH_ADDR  = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  localparam int unsigned OP_SYS_RESET  = 0;
  localparam int unsigned OP_READ_FLY   = 1;
  localparam int unsigned OP_WRITE_FLY  = 2;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode #(
  parameter int unsigned CMD_W = 3
) (
  input  logic [CMD_W-1:0] code,
  output logic             is_reset,
  output logic             is_access
);
  import dbg_txn_pkg::*;

  always_comb begin
    is_reset  = (code == CMD_W'(OP_SYS_RESET));
    is_access = (code == CMD_W'(OP_READ_FLY)) || (code == CMD_W'(OP_WRITE_FLY));
  end
endmodule

// File: rtl/dbg_addr_shift.sv
module dbg_addr_shift #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 3,
  localparam int unsigned ADDR_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic [BYTE_W-1:0] lane [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] feed;
    if (g == 0) begin : g_first
      assign feed = byte_in;
    end else begin : g_next
      assign feed = lane[g-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        lane[g] <= '0;
      end else if (shift_en) begin
        lane[g] <= feed;
      end
    end

    assign addr_out[g*BYTE_W +: BYTE_W] = lane[g];
  end
endmodule

// File: rtl/dbg_count_track.sv
module dbg_count_track #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         final_beat
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (step && cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  // a step from 1 or from 0 ends the data phase
  assign final_beat = (cnt <= W'(1));

  assert_cnt_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt <= $past(cnt));
endmodule

// File: rtl/dbg_txn_parser.sv
module dbg_txn_parser #(
  parameter int unsigned CMD_W      = 3,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned ADDR_BYTES = 3,
  localparam int unsigned ADDR_W    = BYTE_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_dir,
  output logic              byte_mode,
  output logic              cmd_strobe,
  output logic [CMD_W-1:0]  cmd_code,
  output logic              cmd_unknown,
  output logic              addr_strobe,
  output logic [ADDR_W-1:0] addr_out,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [BYTE_W-1:0] dat_byte,
  output logic              dat_dir,
  output logic              dat_last
);
  import dbg_txn_pkg::*;

  localparam int unsigned AIDX_W = $clog2(ADDR_BYTES + 1);
  localparam logic [AIDX_W-1:0] AIDX_LAST = AIDX_W'(ADDR_BYTES - 1);

  phase_e            phase;
  logic [AIDX_W-1:0] aidx;
  logic              accept;
  logic              op_reset;
  logic              op_access;
  logic              final_beat;
  logic [BYTE_W-1:0] remaining;

  assign in_ready  = !sync_clear && (!dat_valid || dat_ready);
  assign accept    = in_valid && in_ready;
  assign byte_mode = (phase != PH_CMD);

  dbg_cmd_decode #(.CMD_W(CMD_W)) u_decode (
    .code      (in_data[CMD_W-1:0]),
    .is_reset  (op_reset),
    .is_access (op_access)
  );

  dbg_count_track #(.W(BYTE_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (sync_clear),
    .load       (accept && phase == PH_COUNT),
    .load_val   (in_data),
    .step       (accept && phase == PH_DATA),
    .cnt        (remaining),
    .final_beat (final_beat)
  );

  dbg_addr_shift #(.BYTE_W(BYTE_W), .NBYTES(ADDR_BYTES)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sync_clear || (accept && phase == PH_COUNT)),
    .shift_en (accept && phase == PH_ADDR),
    .byte_in  (in_data),
    .addr_out (addr_out)
  );

  // transaction sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_CMD;
      aidx        <= '0;
      cmd_strobe  <= 1'b0;
      cmd_unknown <= 1'b0;
      cmd_code    <= '0;
      addr_strobe <= 1'b0;
    end else begin
      cmd_strobe  <= 1'b0;
      cmd_unknown <= 1'b0;
      addr_strobe <= 1'b0;
      if (sync_clear) begin
        phase <= PH_CMD;
        aidx  <= '0;
      end else if (accept) begin
        unique case (phase)
          PH_CMD: begin
            cmd_strobe  <= 1'b1;
            cmd_code    <= in_data[CMD_W-1:0];
            cmd_unknown <= !(op_reset || op_access);
            if (op_access) phase <= PH_COUNT;
          end
          PH_COUNT: begin
            phase <= PH_ADDR;
            aidx  <= '0;
          end
          PH_ADDR: begin
            if (aidx == AIDX_LAST) begin
              phase       <= PH_DATA;
              addr_strobe <= 1'b1;
            end else begin
              aidx <= aidx + AIDX_W'(1);
            end
          end
          PH_DATA: begin
            if (final_beat) phase <= PH_CMD;
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

  // data output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_valid <= 1'b0;
      dat_byte  <= '0;
      dat_dir   <= 1'b0;
      dat_last  <= 1'b0;
    end else if (accept && phase == PH_DATA) begin
      dat_valid <= 1'b1;
      dat_byte  <= in_data;
      dat_dir   <= in_dir;
      dat_last  <= final_beat;
    end else if (dat_ready) begin
      dat_valid <= 1'b0;
    end
  end

  assert_sync_to_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clear |=> (!byte_mode && addr_out == '0 && remaining == '0));

  assert_unknown_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unknown |-> (cmd_strobe && !byte_mode));

  assert_access_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && !cmd_unknown && cmd_code != CMD_W'(OP_SYS_RESET)) |-> byte_mode);

  assert_addr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !addr_strobe);

  assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !dat_ready) |=>
      (dat_valid && $stable(dat_byte) && $stable(dat_dir) && $stable(dat_last)));

  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && dat_last) |-> !byte_mode);
endmodule

// File: tb/test_dbg_txn_parser.sv
module test_dbg_txn_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_clear = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_dir = 1'b0;
  logic        byte_mode;
  logic        cmd_strobe;
  logic [2:0]  cmd_code;
  logic        cmd_unknown;
  logic        addr_strobe;
  logic [23:0] addr_out;
  logic        dat_valid;
  logic        dat_ready = 1'b0;
  logic [7:0]  dat_byte;
  logic        dat_dir;
  logic        dat_last;

  int errors = 0;
  int checks = 0;

  // bench model: 0 command, 1 count, 2 address, 3 data
  int          m_phase = 0;
  int          m_cnt = 0;
  int          m_aidx = 0;
  logic [23:0] m_addr = '0;

  always #10 clk = ~clk;

  dbg_txn_parser i_dbg_txn_parser (
    .clk(clk), .rst_n(rst_n), .sync_clear(sync_clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_dir(in_dir),
    .byte_mode(byte_mode), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
    .cmd_unknown(cmd_unknown), .addr_strobe(addr_strobe), .addr_out(addr_out),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .dat_dir(dat_dir), .dat_last(dat_last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_known(input logic [2:0] c);
    return (c <= 3'd2);
  endfunction

  task automatic send(input logic [7:0] d, input logic dr);
    bit exp_cmd = 0, exp_astb = 0, exp_dv = 0, exp_last = 0;
    int ph = m_phase;
    int stall;
    logic [7:0] held;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_dir = dr;
    #1 chk(in_ready == 1'b1, "R9", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    case (ph)
      0: begin
        exp_cmd = 1;
        if (d[2:0] == 3'd1 || d[2:0] == 3'd2) m_phase = 1;
      end
      1: begin m_cnt = d; m_phase = 2; m_aidx = 0; m_addr = '0; end
      2: begin
        m_addr = {m_addr[15:0], d};
        m_aidx++;
        if (m_aidx == 3) begin exp_astb = 1; m_phase = 3; end
      end
      default: begin
        exp_dv = 1;
        if (m_cnt > 0) m_cnt--;
        if (m_cnt == 0) begin exp_last = 1; m_phase = 0; end
      end
    endcase
    chk(cmd_strobe == exp_cmd, exp_cmd ? "R2" : "R5", cmd_strobe, exp_cmd);
    if (exp_cmd) begin
      chk(cmd_code == d[2:0], "R2", cmd_code, d[2:0]);
      chk(cmd_unknown == !is_known(d[2:0]), "R4", cmd_unknown, !is_known(d[2:0]));
      if (d[2:0] == 3'd1 || d[2:0] == 3'd2) chk(byte_mode == 1'b1, "R3", byte_mode, 1);
    end else begin
      chk(cmd_unknown == 1'b0, "R4", cmd_unknown, 0);
    end
    chk(addr_strobe == exp_astb, "R5", addr_strobe, exp_astb);
    if (exp_astb) chk(addr_out == m_addr, "R5", addr_out, m_addr);
    chk(byte_mode == (m_phase != 0), "R6", byte_mode, (m_phase != 0));
    chk(dat_valid == exp_dv, "R7", dat_valid, exp_dv);
    if (exp_dv) begin
      chk(dat_byte == d, "R8", dat_byte, d);
      chk(dat_dir == dr, "R8", dat_dir, dr);
      chk(dat_last == exp_last, "R7", dat_last, exp_last);
      held = dat_byte;
      stall = $urandom_range(0, 3);
      for (int k = 0; k < stall; k++) begin
        in_valid = 1'b1;
        @(negedge clk);
        chk(dat_valid && dat_byte == held && dat_last == exp_last, "R9", dat_byte, held);
        chk(in_ready == 1'b0, "R9", in_ready, 0);
      end
      in_valid = 1'b0;
      dat_ready = 1'b1;
      @(negedge clk);
      dat_ready = 1'b0;
      chk(dat_valid == 1'b0, "R9", dat_valid, 0);
      chk(cmd_strobe == 1'b0, "R9", cmd_strobe, 0);
    end
  endtask

  task automatic do_sync();
    @(negedge clk);
    sync_clear = 1'b1; in_valid = 1'b1; in_data = 8'h01; in_dir = 1'b0;
    #1 chk(in_ready == 1'b0, "R10", in_ready, 0);
    @(posedge clk);
    @(negedge clk);
    sync_clear = 1'b0; in_valid = 1'b0;
    chk(byte_mode == 1'b0, "R10", byte_mode, 0);
    chk(addr_out == '0, "R10", addr_out, 0);
    chk(cmd_strobe == 1'b0, "R10", cmd_strobe, 0);
    m_phase = 0; m_cnt = 0; m_aidx = 0; m_addr = '0;
  endtask

  task automatic txn(input logic [7:0] cmd, input int cnt, input logic [23:0] a);
    int beats;
    send(cmd, 1'b0);
    send(8'(cnt), 1'b0);
    send(a[23:16], 1'b0);
    send(a[15:8], 1'b0);
    send(a[7:0], 1'b0);
    beats = (cnt == 0) ? 1 : cnt;
    for (int b = 0; b < beats; b++) send(8'($urandom), 1'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(byte_mode == 0 && cmd_strobe == 0 && cmd_unknown == 0, "R1", byte_mode, 0);
    chk(addr_strobe == 0 && dat_valid == 0 && addr_out == 0, "R1", addr_out, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);

    // directed: system reset with upper bits set (R2), unknown codes (R4)
    send(8'hF8, 1'b0);
    send(8'h03, 1'b0);
    send(8'hAF, 1'b1);
    // count 0 yields one beat (R7), count 1, count 3
    txn(8'h01, 0, 24'h123456);
    txn(8'h02, 1, 24'hABCDEF);
    txn(8'h01, 3, 24'h00FF01);
    // sync during address assembly (R10)
    send(8'h02, 1'b0);
    send(8'h04, 1'b0);
    send(8'h55, 1'b0);
    do_sync();
    send(8'h00, 1'b0);
    // sync partway through data (R10)
    send(8'h01, 1'b0);
    send(8'h05, 1'b0);
    send(8'h10, 1'b0); send(8'h20, 1'b0); send(8'h30, 1'b0);
    send(8'h99, 1'b1); send(8'h98, 1'b0);
    do_sync();
    txn(8'h02, 2, 24'h7E7E7E);

    // constrained random transactions
    for (int t = 0; t < 40; t++) begin
      logic [7:0] c = 8'($urandom);
      if (($urandom % 4) != 0) c[2:0] = 3'($urandom_range(1, 2));
      if (c[2:0] == 3'd1 || c[2:0] == 3'd2)
        txn(c, $urandom_range(0, 6), 24'($urandom));
      else
        send(c, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule